// File: doc/BRIEF.md
# 8-bit ALU with Condition Flags

An arithmetic and logic unit for a small accumulator-based processor. Each cycle it takes two 8-bit operands, a carry-in, the current condition flags and a 4-bit operation code. It returns an 8-bit result and an updated flag set. The operations are:

- binary add and subtract, each with and without carry or borrow
- the three bitwise logic operations
- increment, decrement and clear
- arithmetic and logical shifts, and rotates through carry
- a packed-BCD decimal adjust

Both outputs are registered, so a result appears one clock after its operands.

The flag vector is 6 bits wide. Bit 5 is V (overflow), bit 4 is H (half-carry), bit 3 is I (interrupt mask), bit 2 is N (negative), bit 1 is Z (zero) and bit 0 is C (carry/borrow). The interrupt mask is not touched by any operation. It is copied from input to output.

Operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 increment, 8 decrement, 9 clear, 10 arithmetic shift left, 11 arithmetic shift right, 12 logical shift right, 13 rotate left through carry, 14 rotate right through carry, and 15 decimal adjust.

Top module: `alu8_flags`

## Requirements
- R1: Output flag bit 3 (I) always equals input flag bit 3 from the cycle before. Flag positions are V=5, H=4, I=3, N=2, Z=1, C=0.
- R2: Add (op 0) and add-with-carry (op 1) give result = a + b (+ cin for op 1) mod 256. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result has the other sign.
- R3: Subtract (op 2) and subtract-with-borrow (op 3) give result = a - b (- cin for op 3) mod 256. C is set when a borrow is needed and V on two's-complement overflow. H is kept.
- R4: AND (op 4), OR (op 5) and XOR (op 6) give the bitwise result and clear V. H and C are kept.
- R5: Increment (op 7) and decrement (op 8) act on operand a. V is set only for 0x7F to 0x80 on increment and for 0x80 to 0x7F on decrement. H and C are kept.
- R6: Clear (op 9) gives a result of 0x00, clears V and N, and sets Z. H and C are kept.
- R7: For ops 10 to 14, C is the bit shifted out, V equals the new N XOR the new C, and H is kept. The results are:
  - op 10: a shifted left with a 0 in bit 0
  - op 11: a shifted right with bit 7 kept
  - op 12: a shifted right with a 0 in bit 7
  - op 13: a shifted left with cin in bit 0
  - op 14: a shifted right with cin in bit 7
- R8: Decimal adjust (op 15) adds 0x06 when the low nibble of a is above 9 or the input H is set. It adds 0x60 when a is above 0x99 or the input C is set. The output C is the input C OR'd with whether the 0x60 correction was applied. V and H are kept.
- R9: For every operation, N equals result bit 7 and Z is set exactly when the result is 0x00.
- R10: Result and flags are registered and change only on the clock edge after the inputs. While reset is low, both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry-in for add/subtract with carry and for rotates |
| flags_i | input | 6 | Incoming flags {V,H,I,N,Z,C} |
| res_o | output | 8 | Registered result |
| flags_o | output | 6 | Registered new flags {V,H,I,N,Z,C} |

## Verification
Every result and flag is due exactly one rising edge after the operands are applied. The bench therefore drives each vector on a falling edge and samples one time unit after the next rising edge, before any new input is driven. One directed step changes the inputs on a falling edge and samples before the following rising edge, to show that the outputs still hold the previous result. The reset check samples the outputs while reset is held low with nonzero inputs applied.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [5:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic [5:0]   flags_o
);
  localparam int FV = 5, FH = 4, FI = 3, FN = 2, FZ = 1, FC = 0;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INC = 4'd7,
                         OP_DEC = 4'd8, OP_CLR = 4'd9, OP_ASL = 4'd10, OP_ASR = 4'd11,
                         OP_LSR = 4'd12, OP_ROL = 4'd13, OP_ROR = 4'd14, OP_DAA = 4'd15;

  logic         use_c;
  logic [W:0]   sum, dif;
  logic [W:0]   half_sum;
  logic         da_lo, da_hi;
  logic [W-1:0] res_d;
  logic         v_d, h_d, c_d;
  logic         unused_nz;

  assign unused_nz = ^flags_i[FN:FZ];
  assign use_c     = (op_i == OP_ADC || op_i == OP_SBC) ? cin_i : 1'b0;
  assign sum       = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, use_c};
  assign dif       = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, use_c};
  assign half_sum  = {1'b0, a_i ^ b_i ^ sum[W-1:0]};
  assign da_lo     = (a_i[3:0] > 4'd9) || flags_i[FH];
  assign da_hi     = (a_i > 8'h99) || flags_i[FC];

  always_comb begin
    res_d = '0;
    v_d   = flags_i[FV];
    h_d   = flags_i[FH];
    c_d   = flags_i[FC];
    case (op_i)
      OP_ADD, OP_ADC: begin
        res_d = sum[W-1:0];
        c_d   = sum[W];
        h_d   = half_sum[4];
        v_d   = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      OP_SUB, OP_SBC: begin
        res_d = dif[W-1:0];
        c_d   = dif[W];
        v_d   = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
      end
      OP_AND: begin res_d = a_i & b_i; v_d = 1'b0; end
      OP_OR:  begin res_d = a_i | b_i; v_d = 1'b0; end
      OP_XOR: begin res_d = a_i ^ b_i; v_d = 1'b0; end
      OP_INC: begin res_d = a_i + 8'd1; v_d = (a_i == 8'h7F); end
      OP_DEC: begin res_d = a_i - 8'd1; v_d = (a_i == 8'h80); end
      OP_CLR: begin res_d = '0; v_d = 1'b0; end
      OP_ASL: begin res_d = {a_i[W-2:0], 1'b0};     c_d = a_i[W-1]; end
      OP_ASR: begin res_d = {a_i[W-1], a_i[W-1:1]}; c_d = a_i[0];   end
      OP_LSR: begin res_d = {1'b0, a_i[W-1:1]};     c_d = a_i[0];   end
      OP_ROL: begin res_d = {a_i[W-2:0], cin_i};    c_d = a_i[W-1]; end
      OP_ROR: begin res_d = {cin_i, a_i[W-1:1]};    c_d = a_i[0];   end
      default: begin
        res_d = a_i + (da_lo ? 8'h06 : 8'h00) + (da_hi ? 8'h60 : 8'h00);
        c_d   = flags_i[FC] | da_hi;
      end
    endcase
    if (op_i >= OP_ASL && op_i <= OP_ROR) v_d = res_d[W-1] ^ c_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      res_o       <= res_d;
      flags_o[FV] <= v_d;
      flags_o[FH] <= h_d;
      flags_o[FI] <= flags_i[FI];
      flags_o[FN] <= res_d[W-1];
      flags_o[FZ] <= (res_d == '0);
      flags_o[FC] <= c_d;
    end
  end

  AST_I_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flags_o[FI] == $past(flags_i[FI])); // R1
  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=>
      !flags_o[FV] && flags_o[FH] == $past(flags_i[FH]) && flags_o[FC] == $past(flags_i[FC])); // R4
  AST_INC_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_INC && a_i == 8'h7F) |=> flags_o[FV] && res_o == 8'h80); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CLR) |=> res_o == '0 && flags_o[FZ] && !flags_o[FN] && !flags_o[FV]); // R6
  AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_ASL && op_i <= OP_ROR) |=> flags_o[FV] == (flags_o[FN] ^ flags_o[FC])); // R7
  AST_DAA_C_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DAA && flags_i[FC]) |=> flags_o[FC]); // R8
  AST_NZ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flags_o[FN] == res_o[W-1] && flags_o[FZ] == (res_o == '0)); // R9
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [5:0] fin = '0;
  logic [7:0] res;
  logic [5:0] fout;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu8_flags dut_i (.clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
                    .cin_i(cin), .flags_i(fin), .res_o(res), .flags_o(fout));

  function automatic logic [13:0] ref_alu(int opc, int x, int y, int ci, logic [5:0] f);
    int r, k;
    bit v, h, n, z, c, lo, hi;
    v = f[5]; h = f[4]; c = f[0]; r = 0; k = 0;
    case (opc)
      0, 1: begin
        k = (opc == 1) ? ci : 0;
        r = x + y + k; c = (r > 255); h = ((x % 16) + (y % 16) + k) > 15; r = r % 256;
        v = ((x >= 128) == (y >= 128)) && ((r >= 128) != (x >= 128));
      end
      2, 3: begin
        k = (opc == 3) ? ci : 0;
        r = x - y - k; c = (r < 0); r = (r + 512) % 256;
        v = ((x >= 128) != (y >= 128)) && ((r >= 128) != (x >= 128));
      end
      4: begin r = x & y; v = 0; end
      5: begin r = x | y; v = 0; end
      6: begin r = x ^ y; v = 0; end
      7: begin r = (x + 1) % 256; v = (x == 127); end
      8: begin r = (x + 255) % 256; v = (x == 128); end
      9: begin r = 0; v = 0; end
      10: begin c = (x >= 128); r = (x * 2) % 256; end
      11: begin c = x % 2; r = x / 2 + ((x >= 128) ? 128 : 0); end
      12: begin c = x % 2; r = x / 2; end
      13: begin c = (x >= 128); r = (x * 2) % 256 + ci; end
      14: begin c = x % 2; r = x / 2 + ci * 128; end
      default: begin
        lo = ((x % 16) > 9) || h;
        hi = (x > 153) || c;
        r = (x + (lo ? 6 : 0) + (hi ? 96 : 0)) % 256;
        c = c || hi;
      end
    endcase
    n = (r >= 128); z = (r == 0);
    if (opc >= 10 && opc <= 14) v = n ^ c;
    return {v, h, f[3], n, z, c, r[7:0]};
  endfunction

  function automatic string tag(int opc);
    case (opc)
      0, 1: return "R2 R9";
      2, 3: return "R3 R9";
      4, 5, 6: return "R4 R9";
      7, 8: return "R5 R9";
      9: return "R6 R9";
      15: return "R8 R9";
      default: return "R7 R9";
    endcase
  endfunction

  task automatic check(string req, logic [13:0] act, logic [13:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got flags=%b res=%h, expected flags=%b res=%h",
               req, act[13:8], act[7:0], exp[13:8], exp[7:0]);
    end
  endtask

  task automatic run(int opc, int x, int y, int ci, logic [5:0] f);
    @(negedge clk);
    op = opc[3:0]; a = x[7:0]; b = y[7:0]; cin = ci[0]; fin = f;
    @(posedge clk); #1;
    check(tag(opc), {fout, res}, ref_alu(opc, x, y, ci, f));
  endtask

  initial begin
    logic [13:0] prev;
    void'($urandom(32'h5A17C3));
    op = 4'd6; a = 8'hFF; b = 8'h0F; fin = 6'h3F; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 reset", {fout, res}, 14'h0);
    @(negedge clk) rst_n = 1'b1;

    // R2 directed
    run(0, 8'h7F, 8'h01, 0, 6'h00);
    run(0, 8'hFF, 8'h01, 0, 6'h00);
    run(1, 8'h0F, 8'h00, 1, 6'h00);
    run(1, 8'h80, 8'h80, 1, 6'h00);
    // R3 directed
    run(2, 8'h80, 8'h01, 0, 6'h10);
    run(2, 8'h00, 8'h01, 0, 6'h00);
    run(3, 8'h05, 8'h05, 1, 6'h00);
    // R4 with flags preset
    run(4, 8'hF0, 8'h0F, 0, 6'h31);
    run(5, 8'h00, 8'h00, 0, 6'h11);
    run(6, 8'hAA, 8'h55, 0, 6'h20);
    // R5
    run(7, 8'h7F, 0, 0, 6'h11);
    run(7, 8'hFF, 0, 0, 6'h00);
    run(8, 8'h80, 0, 0, 6'h01);
    run(8, 8'h00, 0, 0, 6'h00);
    // R6
    run(9, 8'h5A, 8'hA5, 1, 6'h3F);
    // R7
    run(10, 8'h80, 0, 0, 6'h10);
    run(11, 8'h81, 0, 0, 6'h00);
    run(12, 8'h01, 0, 0, 6'h00);
    run(13, 8'h80, 0, 1, 6'h00);
    run(14, 8'h01, 0, 1, 6'h00);
    // R8
    run(15, 8'h9A, 0, 0, 6'h00);
    run(15, 8'h15, 0, 0, 6'h10);
    run(15, 8'h22, 0, 0, 6'h01);
    run(15, 8'h45, 0, 0, 6'h00);
    // R1 interrupt mask set on every op
    for (int o = 0; o < 16; o++) run(o, 8'h3C, 8'hC3, 1, 6'h08);

    // R10: outputs hold until next edge
    prev = {fout, res};
    @(negedge clk);
    op = 4'd9; a = 8'h11; fin = 6'h00;
    #1 check("R10 hold", {fout, res}, prev);
    @(posedge clk); #1;
    check("R10 update", {fout, res}, ref_alu(9, 8'h11, 0, 0, 6'h00));

    for (int i = 0; i < 20000; i++)
      run($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 2, 6'($urandom));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule